// File: doc/BRIEF.md
# Next Program Counter Selector

This block holds the program counter of a single-cycle processor core and works out, every cycle, the address of the next instruction. All address arithmetic is done on 30-bit word addresses, so the two always-zero byte bits of the PC never go through an adder. The decode lines for the current instruction choose among five sources for the next word address:

- **Sequential**: the current word plus one.
- **Branch**: the current word plus one plus a sign-extended 16-bit offset.
- **Jump**: the upper PC bits joined with a 26-bit target field.
- **Register**: a word address taken from a register operand.
- **Trap**: a fixed entry word for operating-system service.

The three conditional branch tests are evaluated inside the block, from the two register operands it receives. The block also puts out the return address for a call, which is the byte address of the following instruction.

Source selection is a fixed priority:

1. Register source.
2. Jump (either the plain jump or the call form).
3. Trap.
4. Any branch whose condition holds.
5. Sequential.

The selection is carried as an enumerated source code:

- `SRC_REG`: register source.
- `SRC_JUMP`: jump source.
- `SRC_TRAP`: trap source.
- `SRC_BRANCH`: branch source.
- `SRC_SEQ`: sequential source.

The PC register has two behaviours:

- **Reset**: a synchronous reset puts it in its reset condition, word 0.
- **Update**: on every other rising edge it takes the selected next word.

Top module: `npc_sel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_word` becomes 0 on that edge, whatever the other inputs are.
- R2: At each rising edge with `rst` low, `pc_word` takes the value that `next_pc` showed before the edge.
- R3: With none of the seven decode lines high, or with only branch lines high and none of their conditions holding, `next_pc` is `pc_word + 1`, wrapping modulo 2^30.
- R4: With `is_jr` high, `next_pc` is `rs_val[31:2]`, whatever the other decode lines are.
- R5: With `is_jr` low and `is_j` or `is_jal` high, `next_pc` is `{pc_word[29:26], jta}`.
- R6: With `is_jr`, `is_j` and `is_jal` low and `is_syscall` high, `next_pc` is `SYS_ADDR[31:2]` (default `SYS_ADDR` 32'h0000_0200, giving word 30'h80).
- R7: With no jump-type line high and `is_bltz` high, the branch is taken when bit 31 of `rs_val` is 1. A taken branch gives `pc_word + 1 + imm16` with `imm16` sign-extended from bit 15.
- R8: With no jump-type line high, `is_beq` takes the branch when `rs_val == rt_val` and `is_bne` when `rs_val != rt_val`. If several branch lines are high, the branch is taken when any one of them has its condition met.
- R9: `link_addr` always equals `{pc_word + 1, 2'b00}`, the byte address of the instruction after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads word 0 |
| imm16 | input | 16 | Branch offset in words, two's complement |
| jta | input | 26 | Jump target word field |
| rs_val | input | 32 | First register operand (jump register source, branch tests) |
| rt_val | input | 32 | Second register operand (equality tests) |
| is_bltz | input | 1 | Branch if first operand negative |
| is_beq | input | 1 | Branch if operands equal |
| is_bne | input | 1 | Branch if operands differ |
| is_j | input | 1 | Direct jump |
| is_jal | input | 1 | Direct jump with link |
| is_jr | input | 1 | Jump to register address |
| is_syscall | input | 1 | Trap to fixed service entry |
| pc_word | output | 30 | Current PC word address (PC bits 31:2) |
| next_pc | output | 30 | Word address selected for the next cycle |
| link_addr | output | 32 | Byte address of the instruction after the current one |

## Verification
The assertions take for granted that every decode line and operand carries a known value at each clock edge out of reset. They also assume that reset is applied before any other activity, since the update and selection properties are held off until a reset has been seen. The per-source properties are conditioned on the exact mix of decode lines they describe, so they make no assumption that the decoder is one-hot. The bench keeps within these conditions by holding reset for the first cycles and by driving every input with a defined value. It then sweeps all 128 combinations of the seven decode lines, including the multi-hot ones a real decoder never produces, against six operand, offset and PC patterns. The PC patterns include the top word of the address space, so the sequential and branch wrap cases are covered.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        SRC_SEQ    = 3'd0,
        SRC_BRANCH = 3'd1,
        SRC_JUMP   = 3'd2,
        SRC_REG    = 3'd3,
        SRC_TRAP   = 3'd4
    } npc_src_e;

    localparam int BR_KINDS = 3;
    localparam int BR_LTZ   = 0;
    localparam int BR_EQ    = 1;
    localparam int BR_NE    = 2;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [BR_KINDS-1:0] kind,
    output logic                taken
);

    logic                same;
    logic [BR_KINDS-1:0] holds;
    logic [BR_KINDS-1:0] hit;

    // One comparator serves both equality tests.
    assign same          = (op_a == op_b);
    assign holds[BR_LTZ] = op_a[DATA_W-1];
    assign holds[BR_EQ]  = same;
    assign holds[BR_NE]  = ~same;

    generate
        for (genvar k = 0; k < BR_KINDS; k++) begin : g_kind
            assign hit[k] = kind[k] & holds[k];
        end
    endgenerate

    assign taken = |hit;

endmodule

// File: rtl/npc_prio.sv
module npc_prio
    import npc_pkg::*;
(
    input  logic     sel_reg,
    input  logic     sel_jump,
    input  logic     sel_trap,
    input  logic     br_taken,
    output npc_src_e src
);

    always_comb begin
        if (sel_reg) begin
            src = SRC_REG;
        end else if (sel_jump) begin
            src = SRC_JUMP;
        end else if (sel_trap) begin
            src = SRC_TRAP;
        end else if (br_taken) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

endmodule

// File: rtl/npc_addr.sv
module npc_addr
    import npc_pkg::*;
#(
    parameter int              WA_W     = 30,
    parameter int              IMM_W    = 16,
    parameter int              JTA_W    = 26,
    parameter logic [WA_W-1:0] SYS_WORD = 30'h80
) (
    input  npc_src_e         src,
    input  logic [WA_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JTA_W-1:0] jta,
    input  logic [WA_W-1:0]  reg_word,
    output logic [WA_W-1:0]  seq,
    output logic [WA_W-1:0]  next
);

    localparam int HI_W  = WA_W - JTA_W;
    localparam int EXT_W = WA_W - IMM_W;

    logic [WA_W-1:0] imm_ext;
    logic [WA_W-1:0] br_word;
    logic [WA_W-1:0] jump_word;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign seq     = pc + 1'b1;
    assign br_word = seq + imm_ext;

    generate
        if (HI_W > 0) begin : g_region
            assign jump_word = {pc[WA_W-1 -: HI_W], jta};
        end else begin : g_full
            assign jump_word = jta[WA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_SEQ:    next = seq;
            SRC_BRANCH: next = br_word;
            SRC_JUMP:   next = jump_word;
            SRC_REG:    next = reg_word;
            SRC_TRAP:   next = SYS_WORD;
            default:    next = seq;
        endcase
    end

endmodule

// File: rtl/npc_sel.sv
module npc_sel
    import npc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                IMM_W    = 16,
    parameter int                JTA_W    = 26,
    parameter logic [ADDR_W-1:0] SYS_ADDR = 'h200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IMM_W-1:0]    imm16,
    input  logic [JTA_W-1:0]    jta,
    input  logic [ADDR_W-1:0]   rs_val,
    input  logic [ADDR_W-1:0]   rt_val,
    input  logic                is_bltz,
    input  logic                is_beq,
    input  logic                is_bne,
    input  logic                is_j,
    input  logic                is_jal,
    input  logic                is_jr,
    input  logic                is_syscall,
    output logic [ADDR_W-3:0]   pc_word,
    output logic [ADDR_W-3:0]   next_pc,
    output logic [ADDR_W-1:0]   link_addr
);

    localparam int              WA_W     = ADDR_W - 2;
    localparam logic [WA_W-1:0] SYS_WORD = SYS_ADDR[ADDR_W-1:2];

    logic [WA_W-1:0]     pc_q;
    logic [WA_W-1:0]     seq_w;
    logic [WA_W-1:0]     next_w;
    logic [BR_KINDS-1:0] kind;
    logic                taken;
    npc_src_e            src;

    assign kind[BR_LTZ] = is_bltz;
    assign kind[BR_EQ]  = is_beq;
    assign kind[BR_NE]  = is_bne;

    npc_cond #(
        .DATA_W (ADDR_W)
    ) u_cond (
        .op_a  (rs_val),
        .op_b  (rt_val),
        .kind  (kind),
        .taken (taken)
    );

    npc_prio u_prio (
        .sel_reg  (is_jr),
        .sel_jump (is_j | is_jal),
        .sel_trap (is_syscall),
        .br_taken (taken),
        .src      (src)
    );

    npc_addr #(
        .WA_W     (WA_W),
        .IMM_W    (IMM_W),
        .JTA_W    (JTA_W),
        .SYS_WORD (SYS_WORD)
    ) u_addr (
        .src      (src),
        .pc       (pc_q),
        .imm      (imm16),
        .jta      (jta),
        .reg_word (rs_val[ADDR_W-1:2]),
        .seq      (seq_w),
        .next     (next_w)
    );

    // PC register: reset to word 0, otherwise follow the selection.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= next_w;
        end
    end

    always_comb begin
        pc_word   = pc_q;
        next_pc   = next_w;
        link_addr = {seq_w, 2'b00};
    end

endmodule

// File: rtl/npc_sel_chk.sv
module npc_sel_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                IMM_W    = 16,
    parameter int                JTA_W    = 26,
    parameter logic [ADDR_W-1:0] SYS_ADDR = 'h200
) (
    input logic              clk,
    input logic              rst,
    input logic [IMM_W-1:0]  imm16,
    input logic [JTA_W-1:0]  jta,
    input logic [ADDR_W-1:0] rs_val,
    input logic [ADDR_W-1:0] rt_val,
    input logic              is_bltz,
    input logic              is_beq,
    input logic              is_bne,
    input logic              is_j,
    input logic              is_jal,
    input logic              is_jr,
    input logic              is_syscall,
    input logic [ADDR_W-3:0] pc_word,
    input logic [ADDR_W-3:0] next_pc,
    input logic [ADDR_W-1:0] link_addr
);

    localparam int WA_W = ADDR_W - 2;
    localparam int HI_W = WA_W - JTA_W;

    logic            armed = 1'b0;
    logic            no_jump;
    logic            no_dec;
    logic [WA_W-1:0] step;
    logic [WA_W-1:0] ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    assign no_jump = !is_jr && !is_j && !is_jal && !is_syscall;
    assign no_dec  = no_jump && !is_bltz && !is_beq && !is_bne;
    assign step    = pc_word + 1'b1;
    assign ext     = {{(WA_W-IMM_W){imm16[IMM_W-1]}}, imm16};

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> pc_word == '0);

    p_follow_next_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> pc_word == $past(next_pc));

    p_seq_idle_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        no_dec |-> next_pc == step);

    p_seq_untaken_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (no_jump && is_bltz && !is_beq && !is_bne && !rs_val[ADDR_W-1]) |-> next_pc == step);

    p_reg_first_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        is_jr |-> next_pc == rs_val[ADDR_W-1:2]);

    p_jump_word_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (!is_jr && (is_j || is_jal)) |-> next_pc == {pc_word[WA_W-1 -: HI_W], jta});

    p_trap_entry_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (!is_jr && !is_j && !is_jal && is_syscall) |-> next_pc == SYS_ADDR[ADDR_W-1:2]);

    p_ltz_taken_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        (no_jump && is_bltz && rs_val[ADDR_W-1]) |-> next_pc == step + ext);

    p_eq_taken_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (no_jump && is_beq && !is_bltz && !is_bne) |->
            next_pc == ((rs_val == rt_val) ? step + ext : step));

    p_ne_taken_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (no_jump && is_bne && !is_bltz && !is_beq) |->
            next_pc == ((rs_val != rt_val) ? step + ext : step));

    p_link_addr_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        link_addr == {step, 2'b00});

endmodule

bind npc_sel npc_sel_chk #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .JTA_W    (JTA_W),
    .SYS_ADDR (SYS_ADDR)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .imm16      (imm16),
    .jta        (jta),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .is_bltz    (is_bltz),
    .is_beq     (is_beq),
    .is_bne     (is_bne),
    .is_j       (is_j),
    .is_jal     (is_jal),
    .is_jr      (is_jr),
    .is_syscall (is_syscall),
    .pc_word    (pc_word),
    .next_pc    (next_pc),
    .link_addr  (link_addr)
);

// File: tb/test_npc_sel.sv
`timescale 1ns/1ps
module test_npc_sel;

    logic        clk;
    logic        rst;
    logic [15:0] imm16;
    logic [25:0] jta;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic        is_bltz, is_beq, is_bne, is_j, is_jal, is_jr, is_syscall;
    logic [29:0] pc_word;
    logic [29:0] next_pc;
    logic [31:0] link_addr;

    int checks = 0;
    int errors = 0;

    npc_sel i_npc_sel (
        .clk        (clk),
        .rst        (rst),
        .imm16      (imm16),
        .jta        (jta),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .is_bltz    (is_bltz),
        .is_beq     (is_beq),
        .is_bne     (is_bne),
        .is_j       (is_j),
        .is_jal     (is_jal),
        .is_jr      (is_jr),
        .is_syscall (is_syscall),
        .pc_word    (pc_word),
        .next_pc    (next_pc),
        .link_addr  (link_addr)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] pcb [6] = '{32'h0040_1000, 32'hFFFF_FFFC, 32'hA000_2000,
                             32'h0000_0000, 32'h7FFF_FF00, 32'h1234_5678};
    logic [31:0] rsv [6] = '{32'h8000_0010, 32'h0000_1234, 32'hFFFF_FFFC,
                             32'h7FFF_FFFC, 32'h4000_0000, 32'h8000_0000};
    logic [31:0] rtv [6] = '{32'h8000_0010, 32'h0000_1235, 32'h0000_0000,
                             32'h7FFF_FFFC, 32'h4000_0000, 32'h0000_0001};
    logic [15:0] imv [6] = '{16'hFFFC, 16'h0005, 16'h7FFF,
                             16'h8000, 16'h0001, 16'hFFFF};
    logic [25:0] jtv [6] = '{26'h2AB_CDEF, 26'h000_0000, 26'h3FF_FFFF,
                             26'h155_5555, 26'h000_0040, 26'h123_4567};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] c);
        {is_syscall, is_jr, is_jal, is_j, is_bne, is_beq, is_bltz} = c;
    endtask

    // Expected next word from the requirements, with the requirement it exercises.
    function automatic logic [29:0] model(input logic [29:0] pc, input logic [6:0] c,
                                          input logic [31:0] rs, input logic [31:0] rt,
                                          input logic [15:0] im, input logic [25:0] jt,
                                          output string tag);
        logic ltz, eq, ne, tk;
        logic [29:0] sx;
        sx  = {{14{im[15]}}, im};
        ltz = c[0] && rs[31];
        eq  = c[1] && (rs == rt);
        ne  = c[2] && (rs != rt);
        tk  = ltz || eq || ne;
        if (c[5]) begin
            tag = "R4 register jump"; return rs[31:2];
        end else if (c[3] || c[4]) begin
            tag = "R5 direct jump"; return {pc[29:26], jt};
        end else if (c[6]) begin
            tag = "R6 trap entry"; return 30'h80;
        end else if (tk) begin
            tag = ltz ? "R7 bltz taken" : "R8 eq/ne taken";
            return pc + 30'd1 + sx;
        end else begin
            tag = "R3 sequential"; return pc + 30'd1;
        end
    endfunction

    task automatic load_pc(input logic [31:0] a);
        drive(7'b010_0000);
        rs_val = a;
        @(posedge clk);
        #2;
        chk("R4 load via register jump", {2'b00, pc_word}, {2'b00, a[31:2]});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        imm16 = '0; jta = '0; rs_val = '0; rt_val = '0;
        drive(7'd0);
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset state", {2'b00, pc_word}, 32'd0);
        chk("R9 link after reset", link_addr, 32'h4);
        rst = 1'b0;

        // Near-exhaustive sweep: every decode mix against six operand patterns.
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 128; c++) begin
                logic [29:0] e;
                logic [29:0] pcw;
                string tag;
                load_pc(pcb[p]);
                pcw = pcb[p][31:2];
                drive(c[6:0]);
                rs_val = rsv[p];
                rt_val = rtv[p];
                imm16  = imv[p];
                jta    = jtv[p];
                #1;
                e = model(pcw, c[6:0], rsv[p], rtv[p], imv[p], jtv[p], tag);
                chk(tag, {2'b00, next_pc}, {2'b00, e});
                chk("R9 link address", link_addr, {pcw + 30'd1, 2'b00});
                @(posedge clk);
                #2;
                chk("R2 register follows selection", {2'b00, pc_word}, {2'b00, e});
            end
        end

        // Reset mid-run overrides a pending register jump.
        load_pc(32'h1234_5678);
        drive(7'b010_0000);
        rs_val = 32'hFFFF_FFF0;
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 reset overrides jump", {2'b00, pc_word}, 32'd0);
        rst = 1'b0;
        drive(7'd0);
        @(posedge clk);
        #2;
        chk("R3 step from zero", {2'b00, pc_word}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule